// File: doc/BRIEF.md
# Channel-Addressed I/O Device Controller

This block is the peripheral end of a shared programmed-I/O bus. Every bus instruction carries a 6-bit channel number, and the controller acts only when that number matches the channel strapped on its `strap_chan` pins. Channel 63 loops back to the processor, so a controller strapped to 63 never answers. Once addressed, an instruction can do four things:

- write one of three 16-bit data registers (A, B, C);
- read one of them back onto the bus;
- send a start, clear or pulse control;
- ask for a skip decision based on the Busy and Done flags.

On the device side, the modelled device receives one-cycle start, clear and pulse strobes and sees the three registers directly. It can load any register with its own data. It reports the end of an operation with a completion strobe, which drops Busy and raises Done on the same clock edge.

Within one instruction the data transfer comes first and the control after it. A start issued together with a register write therefore reaches the device with the new register value already in place. Reads and skip answers are combinational within the instruction cycle. All state is reset synchronously.

Top module: `chan_io_ctrl`

## Requirements
- R1: After reset, A, B and C are zero, Busy and Done are 0, and `dev_start`, `dev_clear` and `dev_pulse` are low.
- R2: The controller is selected only when `bus_io` is high and `bus_chan` equals `strap_chan`. When not selected, `bus_rdata` is zero, `bus_skip` is low, and no register, flag or device strobe changes because of the bus.
- R3: With `strap_chan` equal to 63, the controller is never selected, whatever `bus_chan` carries.
- R4: A selected cycle with `bus_wr` high loads `bus_wdata` at the clock edge into the register picked by `bus_sel` (01 = A, 10 = B, 11 = C). With `bus_sel` = 00, no register is loaded.
- R5: A selected cycle with `bus_rd` high drives the register picked by `bus_sel` onto `bus_rdata` in the same cycle. With `bus_sel` = 00 it drives zero.
- R6: Control code 01 (start) sets Busy and clears Done at the edge, and raises `dev_start` for exactly the following cycle.
- R7: Control code 10 (clear) clears Busy and Done and raises `dev_clear` for one cycle.
- R8: Control code 11 (pulse) raises `dev_pulse` for one cycle and leaves Busy and Done unchanged. Code 00 raises no strobe.
- R9: `dev_done` while Busy is set clears Busy and sets Done on the same edge. `dev_done` while Busy is clear changes nothing.
- R10: A selected cycle with `bus_tst` high drives `bus_skip` in the same cycle according to `bus_cond`: 00 = Busy is 1, 01 = Busy is 0, 10 = Done is 1, 11 = Done is 0.
- R11: When a write and a start come in the same instruction, the register already holds the new value in the cycle that `dev_start` is high.
- R12: `dev_load_sel` (same encoding as `bus_sel`) loads `dev_load_data` into the chosen register. A bus write to the same register in the same cycle takes precedence.
- R13: A clear wins over a simultaneous `dev_done`, leaving both flags 0. A start wins over a simultaneous `dev_done`, leaving Busy 1 and Done 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_chan | input | 6 | Channel this controller answers to |
| bus_io | input | 1 | Instruction present on the bus this cycle |
| bus_chan | input | 6 | Channel addressed by the instruction |
| bus_wr | input | 1 | Write a register from the bus |
| bus_rd | input | 1 | Read a register onto the bus |
| bus_sel | input | 2 | Register select: 01 A, 10 B, 11 C |
| bus_wdata | input | 16 | Write data |
| bus_ctl | input | 2 | Control: 00 none, 01 start, 10 clear, 11 pulse |
| bus_tst | input | 1 | Skip test requested |
| bus_cond | input | 2 | Skip condition code |
| bus_rdata | output | 16 | Read data, zero when not reading |
| bus_skip | output | 1 | Skip answer |
| dev_start | output | 1 | One-cycle start strobe to device |
| dev_clear | output | 1 | One-cycle stop strobe to device |
| dev_pulse | output | 1 | One-cycle special-function strobe |
| dev_done | input | 1 | Device reports completion |
| dev_load_sel | input | 2 | Device register load select |
| dev_load_data | input | 16 | Device load data |
| reg_a | output | 16 | Register A contents |
| reg_b | output | 16 | Register B contents |
| reg_c | output | 16 | Register C contents |
| busy | output | 1 | Busy flag |
| done | output | 1 | Done flag |

## Verification
The bound checker watches the flag transitions on every cycle:

- start, clear and pulse effects;
- completion while busy;
- Busy and Done never both set;
- quiet outputs and frozen state whenever the controller is not selected, including under the reserved strap.

The bench scenarios are what show the register contents. They cover write-then-read of each register, the device load and its precedence against a bus write, and the ordering of a write against the start strobe. They also walk all four skip conditions through idle, busy and done states, and the same-cycle conflicts between control codes and completion.

// File: rtl/chan_io_pkg.sv
package chan_io_pkg;

    localparam int CHW  = 6;
    localparam int DW   = 16;
    localparam int NREG = 3;
    localparam int SELW = $clog2(NREG + 1);

    typedef enum logic [1:0] {
        CTL_NONE  = 2'b00,
        CTL_START = 2'b01,
        CTL_CLEAR = 2'b10,
        CTL_PULSE = 2'b11
    } ctl_e;

    typedef enum logic [1:0] {
        TST_BUSY_SET = 2'b00,
        TST_BUSY_CLR = 2'b01,
        TST_DONE_SET = 2'b10,
        TST_DONE_CLR = 2'b11
    } cond_e;

    typedef struct packed {
        logic busy;
        logic done;
    } flags_t;

    typedef struct packed {
        logic start;
        logic clear;
        logic pulse;
    } strobes_t;

    function automatic logic eval_skip(flags_t f, cond_e c);
        case (c)
            TST_BUSY_SET: return f.busy;
            TST_BUSY_CLR: return !f.busy;
            TST_DONE_SET: return f.done;
            default:      return !f.done;
        endcase
    endfunction

endpackage

// File: rtl/chan_io_match.sv
module chan_io_match #(
    parameter int CW = chan_io_pkg::CHW
) (
    input  logic          io_valid,
    input  logic [CW-1:0] addr,
    input  logic [CW-1:0] strap,
    output logic          hit
);
    localparam logic [CW-1:0] RESERVED = {CW{1'b1}};

    always_comb begin
        hit = io_valid && (addr == strap) && (strap != RESERVED);
    end
endmodule

// File: rtl/chan_io_regs.sv
module chan_io_regs #(
    parameter int W  = chan_io_pkg::DW,
    parameter int N  = chan_io_pkg::NREG,
    parameter int SW = chan_io_pkg::SELW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SW-1:0]     wr_sel,
    input  logic [W-1:0]      wr_data,
    input  logic [SW-1:0]     ld_sel,
    input  logic [W-1:0]      ld_data,
    input  logic [SW-1:0]     rd_sel,
    output logic [W-1:0]      rd_data,
    output logic [N-1:0][W-1:0] regs
);
    for (genvar i = 0; i < N; i++) begin : g_reg
        localparam logic [SW-1:0] CODE = SW'(i + 1);
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[i] <= '0;
            end else if (wr_en && wr_sel == CODE) begin
                regs[i] <= wr_data;
            end else if (ld_sel == CODE) begin
                regs[i] <= ld_data;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < N; k++) begin
            if (rd_sel == SW'(k + 1)) rd_data = regs[k];
        end
    end
endmodule

// File: rtl/chan_io_flags.sv
module chan_io_flags
    import chan_io_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  ctl_e     ctl,
    input  logic     complete,
    output flags_t   flags,
    output strobes_t strobes
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flags   <= '0;
            strobes <= '0;
        end else begin
            strobes <= '0;
            case (ctl)
                CTL_CLEAR: begin
                    flags         <= '0;
                    strobes.clear <= 1'b1;
                end
                CTL_START: begin
                    flags.busy    <= 1'b1;
                    flags.done    <= 1'b0;
                    strobes.start <= 1'b1;
                end
                default: begin
                    if (ctl == CTL_PULSE) strobes.pulse <= 1'b1;
                    if (complete && flags.busy) begin
                        flags.busy <= 1'b0;
                        flags.done <= 1'b1;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/chan_io_ctrl.sv
module chan_io_ctrl
    import chan_io_pkg::*;
#(
    parameter int CW = CHW,
    parameter int W  = DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] strap_chan,
    input  logic          bus_io,
    input  logic [CW-1:0] bus_chan,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [1:0]    bus_sel,
    input  logic [W-1:0]  bus_wdata,
    input  logic [1:0]    bus_ctl,
    input  logic          bus_tst,
    input  logic [1:0]    bus_cond,
    output logic [W-1:0]  bus_rdata,
    output logic          bus_skip,
    output logic          dev_start,
    output logic          dev_clear,
    output logic          dev_pulse,
    input  logic          dev_done,
    input  logic [1:0]    dev_load_sel,
    input  logic [W-1:0]  dev_load_data,
    output logic [W-1:0]  reg_a,
    output logic [W-1:0]  reg_b,
    output logic [W-1:0]  reg_c,
    output logic          busy,
    output logic          done
);
    logic                  hit;
    logic [W-1:0]          rd_data;
    logic [NREG-1:0][W-1:0] regs;
    ctl_e                  ctl_eff;
    flags_t                flags;
    strobes_t              strobes;

    chan_io_match #(.CW(CW)) u_match (
        .io_valid (bus_io),
        .addr     (bus_chan),
        .strap    (strap_chan),
        .hit      (hit)
    );

    chan_io_regs #(.W(W), .N(NREG), .SW(SELW)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (hit && bus_wr),
        .wr_sel  (bus_sel),
        .wr_data (bus_wdata),
        .ld_sel  (dev_load_sel),
        .ld_data (dev_load_data),
        .rd_sel  (bus_sel),
        .rd_data (rd_data),
        .regs    (regs)
    );

    always_comb begin
        ctl_eff = hit ? ctl_e'(bus_ctl) : CTL_NONE;
    end

    chan_io_flags u_flags (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl_eff),
        .complete (dev_done),
        .flags    (flags),
        .strobes  (strobes)
    );

    always_comb begin
        bus_rdata = (hit && bus_rd) ? rd_data : '0;
        bus_skip  = hit && bus_tst && eval_skip(flags, cond_e'(bus_cond));
        dev_start = strobes.start;
        dev_clear = strobes.clear;
        dev_pulse = strobes.pulse;
        reg_a     = regs[0];
        reg_b     = regs[1];
        reg_c     = regs[2];
        busy      = flags.busy;
        done      = flags.done;
    end
endmodule

// File: rtl/chan_io_ctrl_chk.sv
module chan_io_ctrl_chk #(
    parameter int CW = 6,
    parameter int W  = 16
) (
    input logic          clk,
    input logic          rst,
    input logic [CW-1:0] strap_chan,
    input logic          bus_io,
    input logic [CW-1:0] bus_chan,
    input logic [1:0]    bus_ctl,
    input logic [W-1:0]  bus_rdata,
    input logic          bus_skip,
    input logic          dev_start,
    input logic          dev_clear,
    input logic          dev_pulse,
    input logic          dev_done,
    input logic [1:0]    dev_load_sel,
    input logic [W-1:0]  reg_a,
    input logic [W-1:0]  reg_b,
    input logic [W-1:0]  reg_c,
    input logic          busy,
    input logic          done
);
    logic sel_now;
    always_comb sel_now = bus_io && (bus_chan == strap_chan) && (strap_chan != {CW{1'b1}});

    assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    assert_start_sets_busy_R6: assert property (@(posedge clk) disable iff (rst)
        (sel_now && bus_ctl == 2'b01) |=> (busy && !done && dev_start));

    assert_clear_drops_flags_R7: assert property (@(posedge clk) disable iff (rst)
        (sel_now && bus_ctl == 2'b10) |=> (!busy && !done && dev_clear));

    assert_pulse_keeps_flags_R8: assert property (@(posedge clk) disable iff (rst)
        (sel_now && bus_ctl == 2'b11 && !dev_done) |=>
            (dev_pulse && $stable(busy) && $stable(done)));

    assert_completion_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && dev_done && !(sel_now && bus_ctl != 2'b00)) |=> (done && !busy));

    assert_unselected_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !sel_now |-> (bus_rdata == '0 && !bus_skip));

    assert_unselected_frozen_R2: assert property (@(posedge clk) disable iff (rst)
        (!sel_now && !dev_done && dev_load_sel == 2'b00) |=>
            ($stable(reg_a) && $stable(reg_b) && $stable(reg_c) &&
             $stable(busy) && $stable(done) && !dev_start && !dev_clear && !dev_pulse));

    assert_reserved_strap_R3: assert property (@(posedge clk) disable iff (rst)
        (strap_chan == {CW{1'b1}}) |-> (bus_rdata == '0 && !bus_skip));
endmodule

bind chan_io_ctrl chan_io_ctrl_chk #(.CW(CW), .W(W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .strap_chan   (strap_chan),
    .bus_io       (bus_io),
    .bus_chan     (bus_chan),
    .bus_ctl      (bus_ctl),
    .bus_rdata    (bus_rdata),
    .bus_skip     (bus_skip),
    .dev_start    (dev_start),
    .dev_clear    (dev_clear),
    .dev_pulse    (dev_pulse),
    .dev_done     (dev_done),
    .dev_load_sel (dev_load_sel),
    .reg_a        (reg_a),
    .reg_b        (reg_b),
    .reg_c        (reg_c),
    .busy         (busy),
    .done         (done)
);

// File: tb/chan_io_ctrl_test.sv
module chan_io_ctrl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  strap_chan = 6'd5;
    logic        bus_io = 1'b0;
    logic [5:0]  bus_chan = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [1:0]  bus_sel = '0;
    logic [15:0] bus_wdata = '0;
    logic [1:0]  bus_ctl = '0;
    logic        bus_tst = 1'b0;
    logic [1:0]  bus_cond = '0;
    logic [15:0] bus_rdata;
    logic        bus_skip;
    logic        dev_start, dev_clear, dev_pulse;
    logic        dev_done = 1'b0;
    logic [1:0]  dev_load_sel = '0;
    logic [15:0] dev_load_data = '0;
    logic [15:0] reg_a, reg_b, reg_c;
    logic        busy, done;

    int checks = 0;
    int errors = 0;
    logic [15:0] cap_rdata;
    logic        cap_skip;

    chan_io_ctrl uut (.*);

    always #2 clk = ~clk;

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual hung expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // One clock cycle: drive at negedge, capture combinational replies, clear after edge.
    task automatic step(logic io, logic [5:0] ch, logic wr, logic rd, logic [1:0] sel,
                        logic [15:0] wd, logic [1:0] ctl, logic tst, logic [1:0] cond,
                        logic dd, logic [1:0] dsel, logic [15:0] dd_data);
        @(negedge clk);
        bus_io = io; bus_chan = ch; bus_wr = wr; bus_rd = rd; bus_sel = sel;
        bus_wdata = wd; bus_ctl = ctl; bus_tst = tst; bus_cond = cond;
        dev_done = dd; dev_load_sel = dsel; dev_load_data = dd_data;
        #1;
        cap_rdata = bus_rdata;
        cap_skip  = bus_skip;
        @(posedge clk);
        #1;
        bus_io = 0; bus_wr = 0; bus_rd = 0; bus_sel = 0; bus_ctl = 0; bus_tst = 0;
        dev_done = 0; dev_load_sel = 0;
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic bwrite(logic [5:0] ch, logic [1:0] sel, logic [15:0] d);
        step(1, ch, 1, 0, sel, d, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic bread(logic [5:0] ch, logic [1:0] sel);
        step(1, ch, 0, 1, sel, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic bctl(logic [5:0] ch, logic [1:0] ctl);
        step(1, ch, 0, 0, 0, 0, ctl, 0, 0, 0, 0, 0);
    endtask

    task automatic bskip(logic [5:0] ch, logic [1:0] cond);
        step(1, ch, 0, 0, 0, 0, 0, 1, cond, 0, 0, 0);
    endtask

    task automatic skip_all(string tag, logic [3:0] exp);
        for (int c = 0; c < 4; c++) begin
            bskip(6'd5, c[1:0]);
            check(tag, {15'd0, cap_skip}, {15'd0, exp[c]});
        end
    endtask

    task automatic t_reset();
        check("R1 reg_a", reg_a, 0);
        check("R1 reg_b", reg_b, 0);
        check("R1 reg_c", reg_c, 0);
        check("R1 flags", {14'd0, busy, done}, 0);
        check("R1 strobes", {13'd0, dev_start, dev_clear, dev_pulse}, 0);
    endtask

    task automatic t_write_read();
        bwrite(6'd5, 2'b01, 16'h1234);
        bwrite(6'd5, 2'b10, 16'habcd);
        bwrite(6'd5, 2'b11, 16'h0f0f);
        check("R4 reg_a", reg_a, 16'h1234);
        check("R4 reg_b", reg_b, 16'habcd);
        check("R4 reg_c", reg_c, 16'h0f0f);
        bwrite(6'd5, 2'b00, 16'hffff);
        check("R4 sel none A", reg_a, 16'h1234);
        check("R4 sel none C", reg_c, 16'h0f0f);
        bread(6'd5, 2'b01); check("R5 read A", cap_rdata, 16'h1234);
        bread(6'd5, 2'b10); check("R5 read B", cap_rdata, 16'habcd);
        bread(6'd5, 2'b11); check("R5 read C", cap_rdata, 16'h0f0f);
        bread(6'd5, 2'b00); check("R5 read none", cap_rdata, 0);
    endtask

    task automatic t_other_chan();
        bwrite(6'd9, 2'b01, 16'h7777);
        check("R2 foreign write", reg_a, 16'h1234);
        bread(6'd9, 2'b01);
        check("R2 foreign read", cap_rdata, 0);
        bctl(6'd9, 2'b01);
        check("R2 foreign start", {14'd0, busy, dev_start}, 0);
        step(1, 6'd9, 0, 0, 0, 0, 0, 1, 2'b01, 0, 0, 0);
        check("R2 foreign skip", {15'd0, cap_skip}, 0);
        step(0, 6'd5, 1, 1, 2'b01, 16'h6666, 2'b01, 0, 0, 0, 0, 0);
        check("R2 no bus_io", {reg_a[15:2], busy, dev_start}, {14'h048d, 2'b00});
    endtask

    task automatic t_start_done();
        skip_all("R10 idle", 4'b1010);
        bctl(6'd5, 2'b01);
        check("R6 start", {13'd0, busy, done, dev_start}, 3'b101);
        idle();
        check("R6 strobe one cycle", {15'd0, dev_start}, 0);
        skip_all("R10 busy", 4'b1001);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
        check("R9 complete", {14'd0, busy, done}, 2'b01);
        skip_all("R10 done", 4'b0110);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
        check("R9 idle done ignored", {14'd0, busy, done}, 2'b01);
        bctl(6'd5, 2'b01);
        check("R6 start clears done", {14'd0, busy, done}, 2'b10);
        idle();
    endtask

    task automatic t_clear();
        bctl(6'd5, 2'b10);
        check("R7 clear", {13'd0, busy, done, dev_clear}, 3'b001);
        idle();
        check("R7 strobe one cycle", {15'd0, dev_clear}, 0);
        bctl(6'd5, 2'b01);
        idle();
        step(1, 6'd5, 0, 0, 0, 0, 2'b10, 0, 0, 1, 0, 0);
        check("R13 clear beats done", {14'd0, busy, done}, 0);
        bctl(6'd5, 2'b01);
        idle();
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
        step(1, 6'd5, 0, 0, 0, 0, 2'b01, 0, 0, 1, 0, 0);
        check("R13 start beats done", {14'd0, busy, done}, 2'b10);
        idle();
    endtask

    task automatic t_pulse();
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
        bctl(6'd5, 2'b11);
        check("R8 pulse", {13'd0, dev_pulse, busy, done}, 3'b101);
        idle();
        check("R8 pulse one cycle", {15'd0, dev_pulse}, 0);
        bctl(6'd5, 2'b00);
        check("R8 no control", {11'd0, dev_start, dev_clear, dev_pulse, busy, done}, 5'b00001);
    endtask

    task automatic t_order();
        step(1, 6'd5, 1, 0, 2'b01, 16'h5555, 2'b01, 0, 0, 0, 0, 0);
        check("R11 start strobe", {15'd0, dev_start}, 1);
        check("R11 data with start", reg_a, 16'h5555);
        idle();
    endtask

    task automatic t_devload();
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 2'b10, 16'h2222);
        check("R12 device load", reg_b, 16'h2222);
        step(1, 6'd5, 1, 0, 2'b10, 16'h3333, 0, 0, 0, 0, 2'b10, 16'h4444);
        check("R12 bus wins", reg_b, 16'h3333);
        step(1, 6'd5, 1, 0, 2'b01, 16'h1111, 0, 0, 0, 0, 2'b11, 16'h9999);
        check("R12 split A", reg_a, 16'h1111);
        check("R12 split C", reg_c, 16'h9999);
    endtask

    task automatic t_strap63();
        bctl(6'd5, 2'b10);
        @(negedge clk); strap_chan = 6'd63;
        bwrite(6'd63, 2'b01, 16'hdead);
        check("R3 reserved write", reg_a, 16'h1111);
        bread(6'd63, 2'b01);
        check("R3 reserved read", cap_rdata, 0);
        bctl(6'd63, 2'b01);
        check("R3 reserved start", {14'd0, busy, dev_start}, 0);
        step(1, 6'd63, 0, 0, 0, 0, 0, 1, 2'b01, 0, 0, 0);
        check("R3 reserved skip", {15'd0, cap_skip}, 0);
        @(negedge clk); strap_chan = 6'd5;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_write_read();
        t_other_chan();
        t_start_done();
        t_clear();
        t_pulse();
        t_order();
        t_devload();
        t_strap63();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule